// File: doc/BRIEF.md
# Daisy-Chain Position and Length Detector

Each codec in a chain of serially linked devices carries one copy of this block. When reset is released, it spends a fixed number of master-clock cycles timing how long two edges take to travel along the chain. In the first window it measures the delay until the frame-sync-delayed level coming back from the chain goes high. In the second window it measures the delay until the incoming frame sync is driven low. The first measurement tells the device its own slot in the chain. Adding the two measurements gives the number of devices in the chain.

The two results are registered at the end of the second window, and a done flag is raised at the same time. Results and flag then hold until the next reset. If an awaited edge never arrives, the count for that window stops at the window length and a timeout flag is set. The window length is a parameter. By default it is 64 cycles, so the results are ready 128 cycles after reset.

Top module: `casc_pos_detect`

## Requirements
- R1: While rst_ni is low, done_o, timeout_o, position_o and dev_count_o are all 0.
- R2: done_o rises on exactly the 128th rising clk_i edge after rst_ni goes high, and is 0 after every earlier edge.
- R3: position_o equals the number of edges in the first window (edges 1 to 64 after release) that sample fsd_i low before the first edge that samples it high. If fsd_i is high at edge 1, position_o is 0.
- R4: The second-window count is the number of edges in the second window (edges 65 to 128) that sample fs_i high before the first edge that samples it low. If fs_i is low at edge 65, the count is 0.
- R5: dev_count_o equals position_o plus the second-window count.
- R6: If fsd_i is never sampled high during the first window, position_o is 64 and timeout_o is 1.
- R7: If fs_i is never sampled low during the second window, the second-window count is 64 and timeout_o is 1. When both edges arrive, timeout_o is 0.
- R8: Once a window's edge has been seen, that window's count is frozen. Later changes of the same input within the window do not change it.
- R9: fs_i has no effect during the first window, and fsd_i has no effect during the second window or after done.
- R10: After done_o rises, done_o, position_o, dev_count_o and timeout_o keep their values until rst_ni goes low again, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock; all counting is in its rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset; detection starts on release |
| fs_i | input | 1 | Incoming frame sync; awaited low in the second window |
| fsd_i | input | 1 | Frame-sync-delayed level seen from the chain; awaited high in the first window |
| dev_count_o | output | 8 | Number of devices in the chain |
| position_o | output | 7 | This device's channel address |
| done_o | output | 1 | High from the end of the second window until reset |
| timeout_o | output | 1 | Set with done when either awaited edge was missing |

## Verification
All results appear together, registered on the 128th edge after reset release. The inputs for edge k are applied at the falling edge before it. done_o is checked at the falling edge after edge 127, where it must still be low, and again after edge 128, where it must be high. Position, count and timeout are checked at that same falling edge. Every expected value comes from the edge indices at which the bench placed the awaited transitions. The hold behaviour is checked by reading all outputs again after a stretch of random input activity.

// File: rtl/casc_det_pkg.sv
package casc_det_pkg;

    // Measurement sequence: first window waits for the delayed-sync level,
    // second window waits for the frame sync to fall, then results freeze.
    typedef enum logic [1:0] {
        PH_WAIT_DLY  = 2'd0,
        PH_WAIT_SYNC = 2'd1,
        PH_FROZEN    = 2'd2
    } det_phase_e;

endpackage

// File: rtl/casc_det_window.sv
module casc_det_window
    import casc_det_pkg::*;
#(
    parameter int WIN_LEN = 64
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    output det_phase_e phase_o,
    output logic       win_last_o
);

    localparam int TW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [TW-1:0] LAST_TICK = TW'(WIN_LEN - 1);

    typedef struct packed {
        det_phase_e    phase;
        logic [TW-1:0] tick;
    } win_state_t;

    win_state_t st_d, st_q;
    logic       at_last;

    assign at_last = (st_q.tick == LAST_TICK);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_WAIT_DLY: begin
                if (at_last) begin
                    st_d.phase = PH_WAIT_SYNC;
                    st_d.tick  = '0;
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
            PH_WAIT_SYNC: begin
                if (at_last) begin
                    st_d.phase = PH_FROZEN;
                    st_d.tick  = '0;
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
            default: begin
                st_d.phase = PH_FROZEN;
                st_d.tick  = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.phase <= PH_WAIT_DLY;
            st_q.tick  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o    = st_q.phase;
    assign win_last_o = at_last && (st_q.phase != PH_FROZEN);

    // R2: once frozen the sequence never restarts without reset
    p_frozen_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_FROZEN) |=> (st_q.phase == PH_FROZEN));

    // R2: second window only entered from the end of the first
    p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.phase == PH_WAIT_SYNC) |-> ($past(st_q.phase) == PH_WAIT_DLY));

endmodule

// File: rtl/casc_det_edge_timer.sv
module casc_det_edge_timer #(
    parameter int WIN_LEN      = 64,
    parameter bit ACTIVE_LEVEL = 1'b1,
    localparam int CW = $clog2(WIN_LEN + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          sig_i,
    output logic [CW-1:0] cnt_o,
    output logic          seen_o,
    output logic [CW-1:0] cnt_nx_o,
    output logic          seen_nx_o
);

    localparam logic [CW-1:0] CNT_MAX = CW'(WIN_LEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          seen;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       hit;

    generate
        if (ACTIVE_LEVEL) begin : g_wait_high
            assign hit = sig_i;
        end else begin : g_wait_low
            assign hit = ~sig_i;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (en_i && !st_q.seen) begin
            if (hit) begin
                st_d.seen = 1'b1;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt  <= '0;
            st_q.seen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign seen_o    = st_q.seen;
    assign cnt_nx_o  = st_d.cnt;
    assign seen_nx_o = st_d.seen;

    // R6/R7: count never passes the window length
    p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_MAX);

    // R8: after the edge is seen the count is frozen
    p_hold_after_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.seen |=> (st_q.seen && $stable(st_q.cnt)));

    // R9: outside its window the timer does not move
    p_idle_outside_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> ($stable(st_q.cnt) && $stable(st_q.seen)));

endmodule

// File: rtl/casc_pos_detect.sv
module casc_pos_detect
    import casc_det_pkg::*;
#(
    parameter int PHASE_LEN = 64,
    localparam int CW = $clog2(PHASE_LEN + 1),
    localparam int SW = CW + 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          fs_i,
    input  logic          fsd_i,
    output logic [SW-1:0] dev_count_o,
    output logic [CW-1:0] position_o,
    output logic          done_o,
    output logic          timeout_o
);

    det_phase_e    phase;
    logic          win_last;
    logic          en_dly, en_sync, capture;
    logic [CW-1:0] dly_cnt, dly_cnt_nx, sync_cnt, sync_cnt_nx;
    logic          dly_seen, dly_seen_nx, sync_seen, sync_seen_nx;

    typedef struct packed {
        logic [SW-1:0] count;
        logic [CW-1:0] pos;
        logic          err;
        logic          done;
    } res_state_t;

    res_state_t res_d, res_q;

    casc_det_window #(.WIN_LEN(PHASE_LEN)) u_window (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .phase_o    (phase),
        .win_last_o (win_last)
    );

    assign en_dly  = (phase == PH_WAIT_DLY);
    assign en_sync = (phase == PH_WAIT_SYNC);
    assign capture = en_sync && win_last;

    casc_det_edge_timer #(.WIN_LEN(PHASE_LEN), .ACTIVE_LEVEL(1'b1)) u_dly_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_dly),
        .sig_i     (fsd_i),
        .cnt_o     (dly_cnt),
        .seen_o    (dly_seen),
        .cnt_nx_o  (dly_cnt_nx),
        .seen_nx_o (dly_seen_nx)
    );

    casc_det_edge_timer #(.WIN_LEN(PHASE_LEN), .ACTIVE_LEVEL(1'b0)) u_sync_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (en_sync),
        .sig_i     (fs_i),
        .cnt_o     (sync_cnt),
        .seen_o    (sync_seen),
        .cnt_nx_o  (sync_cnt_nx),
        .seen_nx_o (sync_seen_nx)
    );

    always_comb begin
        res_d = res_q;
        if (capture && !res_q.done) begin
            res_d.count = SW'(dly_cnt) + SW'(sync_cnt_nx);
            res_d.pos   = dly_cnt;
            res_d.err   = !dly_seen || !sync_seen_nx;
            res_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            res_q.count <= '0;
            res_q.pos   <= '0;
            res_q.err   <= 1'b0;
            res_q.done  <= 1'b0;
        end else begin
            res_q <= res_d;
        end
    end

    assign dev_count_o = res_q.count;
    assign position_o  = res_q.pos;
    assign done_o      = res_q.done;
    assign timeout_o   = res_q.err;

    // R10: done is sticky and results are frozen while it is high
    p_done_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_q.done |=> (res_q.done && $stable(res_q.count)
                        && $stable(res_q.pos) && $stable(res_q.err)));

    // R2: done only rises when the window sequence reaches its end
    p_done_at_end_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(res_q.done) |-> (phase == PH_FROZEN));

    // R5: the total never falls below this device's position
    p_total_ge_pos_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_q.done |-> (res_q.count >= SW'(res_q.pos)));

    // R6: a saturated position always comes with the timeout flag
    p_pos_timeout_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (res_q.done && res_q.pos == CW'(PHASE_LEN)) |-> res_q.err);

    // R1: nothing reported before done
    p_quiet_before_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !res_q.done |-> (res_q.count == '0 && res_q.pos == '0 && !res_q.err));

endmodule

// File: tb/casc_pos_detect_tb.sv
`timescale 1ns/1ps
module casc_pos_detect_tb;

    localparam int LEN = 64;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       fs_i = 1'b1;
    logic       fsd_i = 1'b0;
    logic [7:0] dev_count_o;
    logic [6:0] position_o;
    logic       done_o;
    logic       timeout_o;

    int checks = 0;
    int errors = 0;

    always #2 clk_i = ~clk_i;

    casc_pos_detect #(.PHASE_LEN(LEN)) u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .fs_i        (fs_i),
        .fsd_i       (fsd_i),
        .dev_count_o (dev_count_o),
        .position_o  (position_o),
        .done_o      (done_o),
        .timeout_o   (timeout_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pos(input int a);
        return (a > LEN) ? LEN : a - 1;
    endfunction

    function automatic int exp_c2(input int b);
        return (b > 2 * LEN) ? LEN : b - LEN - 1;
    endfunction

    function automatic int exp_err(input int a, input int b);
        return ((a > LEN) || (b > 2 * LEN)) ? 1 : 0;
    endfunction

    // a: edge where fsd_i first reads high (LEN+1 = never)
    // b: edge where fs_i first reads low in window two (2*LEN+1 = never)
    task automatic trial(input int a, input int b, input bit noisy);
        rst_ni = 1'b0;
        fs_i   = $urandom_range(1, 0);
        fsd_i  = $urandom_range(1, 0);
        @(negedge clk_i);
        @(negedge clk_i);
        // R1: reset state
        chk("R1 done", int'(done_o), 0);
        chk("R1 outputs", int'(dev_count_o) + int'(position_o) + int'(timeout_o), 0);
        rst_ni = 1'b1;
        for (int k = 1; k <= 2 * LEN; k++) begin
            if (k <= LEN) begin
                // R9: fs_i is free during window one
                fs_i = noisy ? 1'($urandom_range(1, 0)) : 1'b1;
                if (k < a)       fsd_i = 1'b0;
                else if (k == a) fsd_i = 1'b1;
                else             fsd_i = noisy ? 1'($urandom_range(1, 0)) : 1'b1; // R8
            end else begin
                // R9: fsd_i is free during window two
                fsd_i = noisy ? 1'($urandom_range(1, 0)) : 1'b0;
                if (k < b)       fs_i = 1'b1;
                else if (k == b) fs_i = 1'b0;
                else             fs_i = noisy ? 1'($urandom_range(1, 0)) : 1'b0; // R8
            end
            @(posedge clk_i);
            @(negedge clk_i);
            if (k == 2 * LEN - 1) chk("R2 early done", int'(done_o), 0);
        end
        chk("R2 done", int'(done_o), 1);
        chk("R3 position", int'(position_o), exp_pos(a));
        chk("R4 window two", int'(dev_count_o) - int'(position_o), exp_c2(b));
        chk("R5 total", int'(dev_count_o), exp_pos(a) + exp_c2(b));
        chk("R6 R7 timeout", int'(timeout_o), exp_err(a, b));
        for (int k = 0; k < 20; k++) begin
            fs_i  = 1'($urandom_range(1, 0));
            fsd_i = 1'($urandom_range(1, 0));
            @(negedge clk_i);
        end
        // R10: everything held
        chk("R10 done", int'(done_o), 1);
        chk("R10 position", int'(position_o), exp_pos(a));
        chk("R10 total", int'(dev_count_o), exp_pos(a) + exp_c2(b));
        chk("R10 timeout", int'(timeout_o), exp_err(a, b));
    endtask

    initial begin
        void'($urandom(32'd2024));
        // directed corners
        trial(1, LEN + 1, 1'b0);               // R3 zero position, R4 zero count
        trial(LEN, 2 * LEN, 1'b0);             // last edge in each window
        trial(LEN + 1, LEN + 5, 1'b0);         // R6 fsd timeout
        trial(3, 2 * LEN + 1, 1'b0);           // R7 fs timeout
        trial(LEN + 1, 2 * LEN + 1, 1'b1);     // both timeouts, total 128
        trial(5, LEN + 9, 1'b1);               // R8 R9 noise after edges
        // constrained random
        for (int t = 0; t < 24; t++) begin
            trial($urandom_range(LEN + 1, 1), $urandom_range(2 * LEN + 1, LEN + 1),
                  1'($urandom_range(1, 0)));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule